// File: doc/BRIEF.md
# Attraction Memory Coherence Controller

This block keeps coherence for the local store of one node in a machine that has no home memory. Every node's memory behaves as a cache, and a line can settle wherever it is used. The controller holds a small direct-mapped array. Each entry stores a tag, a line state and a single data word that stands in for the line payload. On one side it serves a processor port that issues one read or write at a time and is held off by a stall signal. On the other side it talks to a split-transaction bus that carries typed transactions in both directions.

Transient line states let a request stay open across many bus cycles while the node keeps answering traffic from other nodes. The bus never blocks: there is no back-pressure, and arbitration is handled outside the block. The controller reacts to these events:

- Read misses fetch the line.
- Writes to shared copies request ownership with an erase and wait for an acknowledgment.
- A write that loses an ownership race re-reads the line before it tries again.
- A valid line that must make room is pushed onto the bus, because no other copy may exist.
- Lines pushed by other nodes are accepted only into an empty slot.

Top module: `am_coh_ctrl`

## Requirements
- R1: After synchronous reset every slot is Invalid, `cpu_stall`, `cpu_done` and `bus_out_valid` are low, and the first read of any address misses.
- R2: Transaction kinds on `bus_in_kind`/`bus_out_kind` use fixed codes: erase=0, exclusive=1, read=2, data=3, inject=4, out=5. Codes 6 and 7 are ignored. Line states are coded Invalid=0, Exclusive=1, Shared=2, Reading=3, Waiting=4, Reading-and-Waiting=5. Every bus output is registered and appears one cycle after the cycle that decided it.
- R3: A read miss sends a read transaction for the request address and puts the slot in Reading. A matching data transaction installs the word, sets Shared, and pulses `cpu_done` with that word on `cpu_rdata` while `cpu_stall` drops.
- R4: A request is accepted when `cpu_req_valid` is high and `cpu_stall` is low, and `cpu_stall` is high in the next cycle. A read that hits a Shared or Exclusive line completes one cycle later without bus traffic.
- R5: A write that hits a Shared line sends an erase and enters Waiting, and the processor stays stalled. A matching exclusive transaction stores the write word, sets Exclusive and completes the write. A write that hits an Exclusive line completes locally with no bus traffic.
- R6: An incoming erase that matches a Waiting line moves it to Reading-and-Waiting. The node then sends a read, and the returning data moves the line to Waiting and triggers a new erase.
- R7: A miss whose slot holds a valid line of another tag first sends an out transaction that carries the victim's address and word, then the read.
- R8: An incoming read that matches an Exclusive line is answered with a data transaction that carries the stored word, and the line drops to Shared.
- R9: An incoming erase that matches a Shared or Exclusive line makes it Invalid.
- R10: An incoming inject whose slot is Invalid installs its address and word as Shared and sends nothing.
- R11: An incoming inject whose slot is not Invalid is sent back on the bus unchanged (kind, address and word).
- R12: A write miss sends a read and enters Reading-and-Waiting, then follows the R6 path (data, erase, exclusive) before it completes.
- R13: In any cycle with `bus_in_valid` high, the processor-side step (lookup or send) waits, and the incoming transaction is handled first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Request address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_stall | output | 1 | Request in progress; hold off new requests |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_done` after a read |
| bus_in_valid | input | 1 | Incoming transaction present |
| bus_in_kind | input | 3 | Incoming transaction kind |
| bus_in_addr | input | ADDR_W | Incoming transaction address |
| bus_in_data | input | DATA_W | Incoming transaction word |
| bus_out_valid | output | 1 | Outgoing transaction present |
| bus_out_kind | output | 3 | Outgoing transaction kind |
| bus_out_addr | output | ADDR_W | Outgoing transaction address |
| bus_out_data | output | DATA_W | Outgoing transaction word |

## Verification
A corrupted line state or tag shows up at the ports within a cycle or two of the next access to that slot. Depending on the corruption, a hit answers without bus traffic when a read was due, a snooped read gets no data reply, an inject bounces or vanishes, or an eviction pushes the wrong address. A wrong processor phase shows at once as a mismatch in `cpu_stall`, or as a missing or extra bus transaction one cycle after the decision. For that reason the reference model is compared on every clock, not only at completion.

// File: rtl/am_pkg.sv
package am_pkg;

  typedef enum logic [2:0] {
    LS_INV  = 3'd0,
    LS_EXC  = 3'd1,
    LS_SHR  = 3'd2,
    LS_RD   = 3'd3,
    LS_WT   = 3'd4,
    LS_RDWT = 3'd5
  } line_st_e;

  typedef enum logic [2:0] {
    TK_ERASE  = 3'd0,
    TK_EXCL   = 3'd1,
    TK_READ   = 3'd2,
    TK_DATA   = 3'd3,
    TK_INJECT = 3'd4,
    TK_OUT    = 3'd5
  } txn_kind_e;

  typedef enum logic [2:0] {
    CP_IDLE    = 3'd0,
    CP_LOOK    = 3'd1,
    CP_EVICT   = 3'd2,
    CP_SEND_RD = 3'd3,
    CP_SEND_ER = 3'd4,
    CP_WAIT    = 3'd5
  } cpu_ph_e;

endpackage

// File: rtl/am_line_store.sv
module am_line_store
  import am_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output line_st_e          rd_state,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              meta_we,
  input  logic [TAG_W-1:0]  wr_tag,
  input  line_st_e          wr_state,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wr_data
);

  logic [TAG_W-1:0]  tag_mem [LINES];
  line_st_e          st_mem  [LINES];
  logic [DATA_W-1:0] dat_mem [LINES];

  // state bits need a reset, so they live in registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_mem[i] <= LS_INV;
    end else if (meta_we) begin
      st_mem[wr_idx] <= wr_state;
    end
  end

  // tag and data arrays carry no reset: plain distributed RAM
  always_ff @(posedge clk) begin
    if (meta_we) tag_mem[wr_idx] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (data_we) dat_mem[wr_idx] <= wr_data;
  end

  assign rd_tag   = tag_mem[rd_idx];
  assign rd_state = st_mem[rd_idx];
  assign rd_data  = dat_mem[rd_idx];

endmodule

// File: rtl/am_lookup.sv
module am_lookup
  import am_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_e         line_state,
  input  logic [TAG_W-1:0] want_tag,
  output logic             tag_eq,
  output logic             holds_copy,
  output logic             hit
);

  always_comb begin
    tag_eq     = (line_tag == want_tag) && (line_state != LS_INV);
    holds_copy = (line_state == LS_SHR) || (line_state == LS_EXC);
    hit        = tag_eq && holds_copy;
  end

endmodule

// File: rtl/am_bus_drive.sv
module am_bus_drive
  import am_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid,
  input  txn_kind_e         tx_kind,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              out_valid,
  output logic [2:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= tx_valid;
      if (tx_valid) begin
        out_kind <= tx_kind;
        out_addr <= tx_addr;
        out_data <= tx_data;
      end
    end
  end

endmodule

// File: rtl/am_coh_ctrl.sv
module am_coh_ctrl
  import am_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              bus_in_valid,
  input  logic [2:0]        bus_in_kind,
  input  logic [ADDR_W-1:0] bus_in_addr,
  input  logic [DATA_W-1:0] bus_in_data,
  output logic              bus_out_valid,
  output logic [2:0]        bus_out_kind,
  output logic [ADDR_W-1:0] bus_out_addr,
  output logic [DATA_W-1:0] bus_out_data
);

  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  cpu_ph_e           fsm_q, fsm_d;
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_wr_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [ADDR_W-1:0] vic_addr_q;
  logic [DATA_W-1:0] vic_data_q;
  logic              done_q, done_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              vic_we;

  // one lookup per cycle: the bus side wins the port (R13)
  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  look_tag;

  logic [TAG_W-1:0]  lk_tag;
  line_st_e          lk_state;
  logic [DATA_W-1:0] lk_data;
  logic              lk_match, lk_valid, lk_hit;

  logic              meta_we, data_we;
  line_st_e          meta_st;
  logic [TAG_W-1:0]  meta_tag;
  logic [DATA_W-1:0] data_wr;

  logic              tx_valid;
  txn_kind_e         tx_kind;
  logic [ADDR_W-1:0] tx_addr;
  logic [DATA_W-1:0] tx_data;

  assign look_addr = bus_in_valid ? bus_in_addr : req_addr_q;
  assign look_idx  = look_addr[IDX_W-1:0];
  assign look_tag  = look_addr[ADDR_W-1:IDX_W];

  am_line_store #(
    .LINES (LINES),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (look_idx),
    .rd_tag  (lk_tag),
    .rd_state(lk_state),
    .rd_data (lk_data),
    .wr_idx  (look_idx),
    .meta_we (meta_we),
    .wr_tag  (meta_tag),
    .wr_state(meta_st),
    .data_we (data_we),
    .wr_data (data_wr)
  );

  am_lookup #(
    .TAG_W(TAG_W)
  ) u_lookup (
    .line_tag  (lk_tag),
    .line_state(lk_state),
    .want_tag  (look_tag),
    .tag_eq    (lk_match),
    .holds_copy(lk_valid),
    .hit       (lk_hit)
  );

  am_bus_drive #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_bus (
    .clk      (clk),
    .rst      (rst),
    .tx_valid (tx_valid),
    .tx_kind  (tx_kind),
    .tx_addr  (tx_addr),
    .tx_data  (tx_data),
    .out_valid(bus_out_valid),
    .out_kind (bus_out_kind),
    .out_addr (bus_out_addr),
    .out_data (bus_out_data)
  );

  always_comb begin
    fsm_d    = fsm_q;
    done_d   = 1'b0;
    rdata_d  = rdata_q;
    meta_we  = 1'b0;
    meta_st  = lk_state;
    meta_tag = look_tag;
    data_we  = 1'b0;
    data_wr  = bus_in_data;
    tx_valid = 1'b0;
    tx_kind  = TK_OUT;
    tx_addr  = req_addr_q;
    tx_data  = '0;
    vic_we   = 1'b0;

    if (bus_in_valid) begin
      unique case (bus_in_kind)
        TK_ERASE: begin
          if (lk_hit) begin                                // R9
            meta_we = 1'b1;
            meta_st = LS_INV;
          end else if (lk_match && lk_state == LS_WT) begin // R6: lost race
            meta_we = 1'b1;
            meta_st = LS_RDWT;
            fsm_d   = CP_SEND_RD;
          end
        end
        TK_EXCL: begin
          if (lk_match && lk_state == LS_WT) begin          // R5
            meta_we = 1'b1;
            meta_st = LS_EXC;
            data_we = 1'b1;
            data_wr = req_wdata_q;
            done_d  = 1'b1;
            fsm_d   = CP_IDLE;
          end
        end
        TK_READ: begin
          if (lk_match && lk_state == LS_EXC) begin         // R8
            meta_we  = 1'b1;
            meta_st  = LS_SHR;
            tx_valid = 1'b1;
            tx_kind  = TK_DATA;
            tx_addr  = bus_in_addr;
            tx_data  = lk_data;
          end
        end
        TK_DATA: begin
          if (lk_match && lk_state == LS_RD) begin          // R3
            meta_we = 1'b1;
            meta_st = LS_SHR;
            data_we = 1'b1;
            rdata_d = bus_in_data;
            done_d  = 1'b1;
            fsm_d   = CP_IDLE;
          end else if (lk_match && lk_state == LS_RDWT) begin // R6, R12
            meta_we = 1'b1;
            meta_st = LS_WT;
            data_we = 1'b1;
            fsm_d   = CP_SEND_ER;
          end
        end
        TK_INJECT: begin
          if (lk_state == LS_INV) begin                     // R10
            meta_we = 1'b1;
            meta_st = LS_SHR;
            data_we = 1'b1;
          end else begin                                    // R11
            tx_valid = 1'b1;
            tx_kind  = TK_INJECT;
            tx_addr  = bus_in_addr;
            tx_data  = bus_in_data;
          end
        end
        default: ;
      endcase
    end else begin
      unique case (fsm_q)
        CP_LOOK: begin
          if (!req_wr_q && lk_hit) begin                    // R4
            rdata_d = lk_data;
            done_d  = 1'b1;
            fsm_d   = CP_IDLE;
          end else if (req_wr_q && lk_hit && lk_state == LS_EXC) begin
            data_we = 1'b1;
            data_wr = req_wdata_q;
            done_d  = 1'b1;
            fsm_d   = CP_IDLE;
          end else if (req_wr_q && lk_hit) begin            // R5
            meta_we = 1'b1;
            meta_st = LS_WT;
            fsm_d   = CP_SEND_ER;
          end else begin                                    // miss: R3, R7, R12
            vic_we  = lk_valid;
            meta_we = 1'b1;
            meta_st = req_wr_q ? LS_RDWT : LS_RD;
            fsm_d   = lk_valid ? CP_EVICT : CP_SEND_RD;
          end
        end
        CP_EVICT: begin
          tx_valid = 1'b1;
          tx_kind  = TK_OUT;
          tx_addr  = vic_addr_q;
          tx_data  = vic_data_q;
          fsm_d    = CP_SEND_RD;
        end
        CP_SEND_RD: begin
          tx_valid = 1'b1;
          tx_kind  = TK_READ;
          fsm_d    = CP_WAIT;
        end
        CP_SEND_ER: begin
          tx_valid = 1'b1;
          tx_kind  = TK_ERASE;
          fsm_d    = CP_WAIT;
        end
        default: ;
      endcase
    end

    if (fsm_q == CP_IDLE && cpu_req_valid) fsm_d = CP_LOOK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm_q   <= CP_IDLE;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      fsm_q   <= fsm_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fsm_q == CP_IDLE && cpu_req_valid) begin
      req_addr_q  <= cpu_req_addr;
      req_wr_q    <= cpu_req_write;
      req_wdata_q <= cpu_req_wdata;
    end
    if (vic_we) begin
      vic_addr_q <= {lk_tag, look_idx};
      vic_data_q <= lk_data;
    end
  end

  assign cpu_stall = (fsm_q != CP_IDLE);
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

endmodule

// File: rtl/am_coh_checker.sv
module am_coh_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req_valid,
  input logic              cpu_stall,
  input logic              cpu_done,
  input logic              bus_in_valid,
  input logic [2:0]        bus_in_kind,
  input logic [ADDR_W-1:0] bus_in_addr,
  input logic              bus_out_valid,
  input logic [2:0]        bus_out_kind,
  input logic [ADDR_W-1:0] bus_out_addr,
  input logic [2:0]        lk_state,
  input logic              lk_match
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cpu_stall && !cpu_done && !bus_out_valid));

  p_kind_legal_r2: assert property (@(posedge clk) disable iff (rst)
    bus_out_valid |-> (bus_out_kind <= 3'd5));

  p_done_unstalls_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_stall);

  p_accept_stalls_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_req_valid && !cpu_stall) |=> cpu_stall);

  p_read_answer_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_in_valid && bus_in_kind == 3'd2 && lk_match && lk_state == 3'd1)
    |=> (bus_out_valid && bus_out_kind == 3'd3 && bus_out_addr == $past(bus_in_addr)));

  p_inject_take_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_in_valid && bus_in_kind == 3'd4 && lk_state == 3'd0) |=> !bus_out_valid);

  p_inject_bounce_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_in_valid && bus_in_kind == 3'd4 && lk_state != 3'd0)
    |=> (bus_out_valid && bus_out_kind == 3'd4 && bus_out_addr == $past(bus_in_addr)));

endmodule

bind am_coh_ctrl am_coh_checker #(.ADDR_W(ADDR_W)) u_am_coh_checker (
  .clk          (clk),
  .rst          (rst),
  .cpu_req_valid(cpu_req_valid),
  .cpu_stall    (cpu_stall),
  .cpu_done     (cpu_done),
  .bus_in_valid (bus_in_valid),
  .bus_in_kind  (bus_in_kind),
  .bus_in_addr  (bus_in_addr),
  .bus_out_valid(bus_out_valid),
  .bus_out_kind (bus_out_kind),
  .bus_out_addr (bus_out_addr),
  .lk_state     (lk_state),
  .lk_match     (lk_match)
);

// File: tb/am_coh_ctrl_bench.sv
module am_coh_ctrl_bench;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NL = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_v = 1'b0, req_w = 1'b0;
  logic [AW-1:0] req_a = '0;
  logic [DW-1:0] req_d = '0;
  logic          bi_v = 1'b0;
  logic [2:0]    bi_k = '0;
  logic [AW-1:0] bi_a = '0;
  logic [DW-1:0] bi_d = '0;
  logic          cpu_stall, cpu_done, bo_v;
  logic [DW-1:0] cpu_rdata, bo_d;
  logic [2:0]    bo_k;
  logic [AW-1:0] bo_a;

  always #5 clk = ~clk;

  am_coh_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_am_coh_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req_valid(req_v), .cpu_req_write(req_w), .cpu_req_addr(req_a), .cpu_req_wdata(req_d),
    .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_in_valid(bi_v), .bus_in_kind(bi_k), .bus_in_addr(bi_a), .bus_in_data(bi_d),
    .bus_out_valid(bo_v), .bus_out_kind(bo_k), .bus_out_addr(bo_a), .bus_out_data(bo_d)
  );

  // reference model: state codes I=0 E=1 S=2 R=3 W=4 RW=5; kinds per R2
  int ms[NL], mt[NL], md[NL];
  int phase;            // 0 idle 1 look 2 evict 3 send-read 4 send-erase 5 wait
  int ra, rwr, rwd, va, vd;
  bit e_stall, e_done, e_bv;
  int e_rdata, e_bk, e_ba, e_bd;
  int compared = 0, mismatched = 0;
  int cycles = 0;
  string cur_req = "R1";

  task automatic model();
    int ix, tg, st, ph0;
    bit m, cp;
    e_done = 0; e_bv = 0;
    if (rst) begin
      foreach (ms[i]) ms[i] = 0;
      phase = 0; e_rdata = 0; e_stall = 0;
      return;
    end
    ph0 = phase;
    if (bi_v) begin
      ix = bi_a % NL; tg = bi_a / NL; st = ms[ix];
      m = (mt[ix] == tg) && (st != 0);
      cp = m && (st == 1 || st == 2);
      case (bi_k)
        0: if (cp) ms[ix] = 0;
           else if (m && st == 4) begin ms[ix] = 5; phase = 3; end
        1: if (m && st == 4) begin ms[ix] = 1; md[ix] = rwd; e_done = 1; phase = 0; end
        2: if (m && st == 1) begin
             ms[ix] = 2; e_bv = 1; e_bk = 3; e_ba = bi_a; e_bd = md[ix];
           end
        3: if (m && st == 3) begin
             ms[ix] = 2; md[ix] = bi_d; e_rdata = bi_d; e_done = 1; phase = 0;
           end else if (m && st == 5) begin
             ms[ix] = 4; md[ix] = bi_d; phase = 4;
           end
        4: if (st == 0) begin ms[ix] = 2; mt[ix] = tg; md[ix] = bi_d; end
           else begin e_bv = 1; e_bk = 4; e_ba = bi_a; e_bd = bi_d; end
        default: ;
      endcase
    end else begin
      ix = ra % NL; tg = ra / NL; st = ms[ix];
      m = (mt[ix] == tg) && (st != 0);
      cp = m && (st == 1 || st == 2);
      case (phase)
        1: if (!rwr && cp) begin e_rdata = md[ix]; e_done = 1; phase = 0; end
           else if (rwr && cp && st == 1) begin md[ix] = rwd; e_done = 1; phase = 0; end
           else if (rwr && cp) begin ms[ix] = 4; phase = 4; end
           else begin
             if (st == 1 || st == 2) begin va = mt[ix] * NL + ix; vd = md[ix]; end
             phase = (st == 1 || st == 2) ? 2 : 3;
             ms[ix] = rwr ? 5 : 3; mt[ix] = tg;
           end
        2: begin e_bv = 1; e_bk = 5; e_ba = va; e_bd = vd; phase = 3; end
        3: begin e_bv = 1; e_bk = 2; e_ba = ra; e_bd = 0; phase = 5; end
        4: begin e_bv = 1; e_bk = 0; e_ba = ra; e_bd = 0; phase = 5; end
        default: ;
      endcase
    end
    if (ph0 == 0 && req_v) begin
      phase = 1; ra = req_a; rwr = req_w; rwd = req_d;
    end
    e_stall = (phase != 0);
  endtask

  task automatic compare();
    bit bad;
    bad = (cpu_stall !== e_stall) || (cpu_done !== e_done) || (bo_v !== e_bv);
    if (e_done && cpu_rdata !== DW'(e_rdata)) bad = 1;
    if (e_bv && (bo_k !== 3'(e_bk) || bo_a !== AW'(e_ba))) bad = 1;
    if (e_bv && e_bk != 0 && e_bk != 2 && bo_d !== DW'(e_bd)) bad = 1;
    compared++;
    if (bad) begin
      mismatched++;
      $display("FAIL %s cyc %0d: stall/done/rdata/bv/kind/addr/data act %b %b %h %b %0d %h %h exp %b %b %h %b %0d %h %h",
               cur_req, cycles, cpu_stall, cpu_done, cpu_rdata, bo_v, bo_k, bo_a, bo_d,
               e_stall, e_done, e_rdata[DW-1:0], e_bv, e_bk, e_ba[AW-1:0], e_bd[DW-1:0]);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    cycles++;
    model();
    #2;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic cpu_op(input bit w, input int a, input int d);
    while (cpu_stall) cyc();
    req_v = 1; req_w = w; req_a = AW'(a); req_d = DW'(d);
    cyc();
    req_v = 0;
  endtask

  task automatic bus_op(input int k, input int a, input int d);
    bi_v = 1; bi_k = 3'(k); bi_a = AW'(a); bi_d = DW'(d);
    cyc();
    bi_v = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    while (cycles < 100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog %s: actual hung, expected completion", cur_req);
    finish_run();
  end

  initial begin
    #3;
    idle(3);                           // R1: reset state compared each cycle
    rst = 0;
    idle(2);

    cur_req = "R3";                    // read miss, data fill
    cpu_op(0, 8'h12, 0); idle(4);
    bus_op(3, 8'h12, 16'hBEEF); idle(2);

    cur_req = "R4";                    // read hit, no bus traffic
    cpu_op(0, 8'h12, 0); idle(3);

    cur_req = "R5";                    // write to Shared, then to Exclusive
    cpu_op(1, 8'h12, 16'hA1A1); idle(4);
    bus_op(1, 8'h12, 0); idle(2);
    cpu_op(1, 8'h12, 16'hA2A2); idle(3);

    cur_req = "R8";                    // snooped read of Exclusive line; R2 kind codes
    bus_op(2, 8'h12, 0); idle(2);

    cur_req = "R6";                    // lost ownership race
    cpu_op(1, 8'h12, 16'h1111); idle(4);
    bus_op(0, 8'h12, 0); idle(3);
    bus_op(3, 8'h12, 16'h2222); idle(3);
    bus_op(1, 8'h12, 0); idle(2);
    cpu_op(0, 8'h12, 0); idle(3);

    cur_req = "R7";                    // eviction of valid victim
    cpu_op(0, 8'h32, 0); idle(5);
    bus_op(3, 8'h32, 16'h3333); idle(2);

    cur_req = "R9";                    // incoming erase invalidates
    bus_op(0, 8'h32, 0); idle(1);
    cpu_op(0, 8'h32, 0); idle(4);
    bus_op(3, 8'h32, 16'h4444); idle(2);

    cur_req = "R10";                   // inject into empty slot
    bus_op(4, 8'h05, 16'h5555); idle(1);
    cpu_op(0, 8'h05, 0); idle(3);

    cur_req = "R11";                   // inject into occupied slot bounces
    bus_op(4, 8'h52, 16'h6666); idle(2);

    cur_req = "R12";                   // write miss path
    cpu_op(1, 8'h07, 16'h7777); idle(4);
    bus_op(3, 8'h07, 16'h0101); idle(3);
    bus_op(1, 8'h07, 0); idle(2);
    cpu_op(0, 8'h07, 0); idle(3);

    cur_req = "R13";                   // bus traffic delays lookup
    req_v = 1; req_w = 0; req_a = 8'h05; req_d = 0;
    cyc();
    req_v = 0;
    bus_op(5, 8'h40, 16'h0F0F);
    bus_op(7, 8'h41, 16'h0E0E);
    idle(3);

    finish_run();
  end

endmodule